// File: doc/BRIEF.md
# GO Line Start Handshake Sequencer

This block decides, for one device in a chain, when that device takes in its next input word. All devices in the chain share one clock, one 16-bit input bus and one bidirectional start line called GO. A static mode input makes the device a follower (slave) or the single leader (master) of the chain. The computation pipeline, the input register file and the host bus are outside this block. Only the host-write pulse reaches it, as an input.

A follower takes its cue from an internal readiness input. That input is raised one clock before the device can accept data. From that edge on, the follower samples GO on every rising edge until it sees GO high. The edge after that sighting is the capture edge, and a one-cycle capture strobe marks it. When the host has written the leader's input register, the leader drives GO high for exactly one cycle. This happens at the first edge at which the leader is itself ready, so every ready device samples the high level on the same edge. The leader then keeps driving GO low. Once GO has fallen, the host may write the next word.

Top module: `go_handshake`

## Requirements
- R1: While reset is held, and on the first cycle after it, `capture`, `go_drv` and `go_oe` are all 0, in both modes.
- R2: A sampling edge is any edge at which `in_ready` is 1, or any later edge at which the device is still waiting for GO. If `go_in` is 1 at a sampling edge, `capture` is 1 for the cycle that follows that edge and is 0 again after the next edge, unless that next edge is also a sampling edge with `go_in` high.
- R3: If `go_in` is 0 at a sampling edge, there is no capture. The device then keeps sampling at every following edge, even with `in_ready` at 0, until it sees `go_in` at 1.
- R4: If `go_in` is 1 at an edge that is not a sampling edge, there is no capture.
- R5: In master mode (`mode_master` = 1), take an edge with `host_wr` at 1 while the device is at a sampling edge and `go_drv` is 0. After that edge, `go_drv` and `go_oe` are both 1 for one cycle. The device's own `capture` follows one cycle later.
- R6: In master mode, a host write that arrives while the device is not ready is held. GO rises after the first later edge that is a sampling edge.
- R7: In master mode, once GO has been raised, `go_oe` stays 1 and `go_drv` returns to 0 after one cycle. The leader keeps driving the line low.
- R8: In slave mode (`mode_master` = 0), `go_oe` and `go_drv` stay 0 whatever `host_wr` does.
- R9: A capture ends the wait. After it, a high `go_in` gives no further capture until `in_ready` is raised again.
- R10: In master mode, several host writes made while one write is still pending give exactly one GO pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared across the chain |
| rst | input | 1 | Synchronous reset, active high |
| mode_master | input | 1 | Static role: 1 makes the device the leader, 0 a follower |
| in_ready | input | 1 | Device will be able to accept data one cycle from now |
| host_wr | input | 1 | One-cycle pulse: the host wrote this device's input register |
| go_in | input | 1 | Resolved level seen on the shared GO line |
| capture | output | 1 | One-cycle strobe: latch the input bus at the next edge |
| go_drv | output | 1 | Level this device puts on GO while it drives the line |
| go_oe | output | 1 | Output enable for the GO driver |

## Verification
The bench holds GO high while the device is not armed. A sequencer that sampled on every edge would capture there. After a capture it keeps GO high with readiness low, which catches a wait flag that does not clear. It also sends GO low while readiness is raised and then drops readiness, so a follower that sampled only while `in_ready` was high would miss the later high level. In master mode the bench sends host writes before the device is ready and sends them several times in a row. A lost pending write would give no GO pulse, and a write counter in place of a flag would give extra pulses. Host writes are also applied in slave mode, where any activity on the GO driver is an error.

// File: rtl/go_hs_pkg.sv
package go_hs_pkg;

    typedef enum logic {
        HS_FOLLOWER = 1'b0,
        HS_LEADER   = 1'b1
    } hs_mode_e;

    typedef struct packed {
        logic waiting;
        logic strobe;
    } hs_sample_t;

    function automatic logic hs_may_fire(hs_mode_e mode, logic req,
                                         logic armed, logic busy);
        return (mode == HS_LEADER) && req && armed && !busy;
    endfunction

endpackage

// File: rtl/go_hs_sampler.sv
module go_hs_sampler
    import go_hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_ready,
    input  logic go_in,
    output logic armed,
    output logic capture
);

    hs_sample_t st_q;

    // a sampling edge: readiness announced now, or an earlier wait still open
    assign armed = in_ready | st_q.waiting;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.strobe  <= armed & go_in;
            st_q.waiting <= armed & ~go_in;
        end
    end

    assign capture = st_q.strobe;

    AST_CAPTURE_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
        capture |-> $past(go_in)); // R2

    AST_NO_CAPTURE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_ready) && !$past(st_q.waiting)) |-> !capture); // R4

endmodule

// File: rtl/go_hs_driver.sv
module go_hs_driver
    import go_hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hs_mode_e mode,
    input  logic     host_wr,
    input  logic     armed,
    output logic     go_drv,
    output logic     go_oe
);

    logic pending_q;
    logic drv_q;
    logic oe_q;
    logic req;
    logic fire;

    assign req  = host_wr | pending_q;
    assign fire = hs_may_fire(mode, req, armed, drv_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            drv_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            pending_q <= (mode == HS_LEADER) & req & ~fire;
            drv_q     <= fire;
            oe_q      <= oe_q | fire;
        end
    end

    assign go_drv = drv_q;
    assign go_oe  = oe_q;

    AST_GO_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        go_drv |=> !go_drv); // R5

    AST_GO_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $rose(go_drv) |-> $past(host_wr | pending_q)); // R6

    AST_OE_STICKY: assert property (@(posedge clk) disable iff (rst)
        go_oe |=> go_oe); // R7

endmodule

// File: rtl/go_handshake.sv
module go_handshake
    import go_hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_master,
    input  logic in_ready,
    input  logic host_wr,
    input  logic go_in,
    output logic capture,
    output logic go_drv,
    output logic go_oe
);

    hs_mode_e mode;
    logic     armed;

    assign mode = hs_mode_e'(mode_master);

    go_hs_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .in_ready (in_ready),
        .go_in    (go_in),
        .armed    (armed),
        .capture  (capture)
    );

    go_hs_driver u_driver (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .host_wr (host_wr),
        .armed   (armed),
        .go_drv  (go_drv),
        .go_oe   (go_oe)
    );

    AST_FOLLOWER_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !mode_master |-> (!go_oe && !go_drv)); // R8

endmodule

// File: tb/go_handshake_tb_top.sv
module go_handshake_tb_top;

    logic clk = 1'b0;
    logic rst;
    logic mode_master;
    logic in_ready;
    logic host_wr;
    logic ext_go;
    logic go_line;
    logic capture;
    logic go_drv;
    logic go_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    assign go_line = go_oe ? go_drv : ext_go;

    go_handshake dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_master (mode_master),
        .in_ready    (in_ready),
        .host_wr     (host_wr),
        .go_in       (go_line),
        .capture     (capture),
        .go_drv      (go_drv),
        .go_oe       (go_oe)
    );

    // each entry: {host_wr, in_ready, ext_go, expected capture}, follower mode
    localparam int NV = 10;
    localparam logic [3:0] VECS [NV] = '{
        4'b1010, // R4 go high, not armed
        4'b0111, // R2 armed, go high
        4'b0010, // R9 wait closed
        4'b0100, // R3 go low, wait opens
        4'b1000, // R3 still waiting
        4'b0011, // R3 go seen while waiting
        4'b0000,
        4'b0111, // R2
        4'b0111, // R2 back-to-back readiness
        4'b0000
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic wr, input logic rdy, input logic go);
        host_wr  = wr;
        in_ready = rdy;
        ext_go   = go;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_idle(input string tag);
        chk(tag, capture, 1'b0);
        chk(tag, go_drv, 1'b0);
        chk(tag, go_oe, 1'b0);
    endtask

    initial begin
        rst = 1'b1; mode_master = 1'b0;
        host_wr = 1'b0; in_ready = 1'b0; ext_go = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1 follower reset");
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0);
        check_idle("R1 follower after reset");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][3], VECS[i][2], VECS[i][1]);
            chk($sformatf("R2/R3/R4/R9 vector %0d capture", i), capture, VECS[i][0]);
            chk($sformatf("R8 vector %0d go_oe", i), go_oe, 1'b0);
            chk($sformatf("R8 vector %0d go_drv", i), go_drv, 1'b0);
        end

        // leader mode
        rst = 1'b1; mode_master = 1'b1;
        host_wr = 1'b0; in_ready = 1'b0; ext_go = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_idle("R1 leader reset");
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0);
        check_idle("R1 leader after reset");

        // R5: write while ready
        step(1'b1, 1'b1, 1'b0);
        chk("R5 go_drv raised", go_drv, 1'b1);
        chk("R5 go_oe raised", go_oe, 1'b1);
        chk("R5 no capture yet", capture, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R5 own capture", capture, 1'b1);
        chk("R7 go_drv back low", go_drv, 1'b0);
        chk("R7 go_oe held", go_oe, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        chk("R2 capture one cycle", capture, 1'b0);

        // R6: write before ready is held
        step(1'b1, 1'b0, 1'b0);
        chk("R6 not ready no go", go_drv, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R6 still held", go_drv, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R6 go on readiness", go_drv, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        chk("R6 capture follows", capture, 1'b1);
        chk("R7 low after pulse", go_drv, 1'b0);

        // R10: repeated writes merge
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R10 no go while unready", go_drv, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R10 single go raised", go_drv, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        chk("R10 capture", capture, 1'b1);
        chk("R10 go dropped", go_drv, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R10 no second pulse a", go_drv, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R10 no second pulse b", go_drv, 1'b0);
        chk("R7 oe still held", go_oe, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule